// File: doc/BRIEF.md
# Sixteen-Bit ALU with Single-Bit Operations

This block is the combinational arithmetic and logic unit of a small RISC core. Each evaluation takes two source operands, a four-bit operation select, a bit index drawn from the low bits of the instruction, and the value of the stored carry flag. It returns the result word together with the next values of the carry flag and the zero flag. The core registers these flags and later tests them with conditional jumps. Operand fetch, result write-back and the flag registers sit outside the block.

There are sixteen operations. Eight are arithmetic: add and subtract, each with or without the stored carry, plus one-bit rotates and shifts in both directions. Eight are logic: bitwise NOT, XOR, OR and AND, and four single-bit operations that keep, flip, set or clear the operand bit selected by the index. The word width is a parameter with a default of 16. The adder can be built as a flat sum or as an explicit ripple chain.

Top module: `alu16_bitops`

## Requirements
- R1: Operation code 2 (plain add) gives result_o = src_a_i + src_b_i modulo 2^WIDTH, and carry_o is the carry out of the top bit. The full code map is: 0 add-with-carry, 1 subtract-with-carry, 2 add, 3 subtract, 4 rotate right, 5 rotate left, 6 shift right, 7 shift left, 8 NOT, 9 XOR, 10 OR, 11 AND, 12 keep bit, 13 flip bit, 14 set bit, 15 clear bit.
- R2: Code 0 adds carry_i to src_a_i + src_b_i, and carry_o is the carry out of the top bit.
- R3: Code 3 gives src_a_i - src_b_i and code 1 gives src_a_i - src_b_i - (1 - carry_i). For both, carry_o is 1 exactly when no borrow occurs.
- R4: Codes 4 and 5 rotate src_a_i by one place, right and left respectively. The bit that wraps around also appears on carry_o.
- R5: Codes 6 and 7 shift src_a_i by one place, right and left respectively, with a zero entering the vacated bit. carry_o is the bit shifted out.
- R6: Codes 8 to 11 give ~src_a_i, src_a_i ^ src_b_i, src_a_i | src_b_i and src_a_i & src_b_i. For these codes carry_o equals carry_i.
- R7: Codes 12 to 15 act on bit number bit_sel_i of src_a_i. Code 12 keeps only that bit and clears all others. Code 13 inverts it, code 14 sets it and code 15 clears it. For these codes carry_o equals carry_i.
- R8: zero_o is 1 exactly when result_o is all zeros, for every operation.
- R9: src_b_i has no effect on the outputs for the single-operand codes 4 to 8 and 12 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation select (code map in R1) |
| src_a_i | input | WIDTH | First source operand |
| src_b_i | input | WIDTH | Second source operand |
| bit_sel_i | input | log2(WIDTH) | Bit index for the single-bit operations |
| carry_i | input | 1 | Stored carry flag |
| result_o | output | WIDTH | Operation result |
| carry_o | output | 1 | Next carry flag value |
| zero_o | output | 1 | Next zero flag value |

## Verification
A carry out and a zero result can both occur in the same evaluation. Examples are a wrapping add such as 0x8000 + 0x8000, a subtract of equal operands, and a shift that pushes out the last set bit. The bench applies such operand pairs directly and checks the carry, the zero flag and the result together against an arithmetic model. A four-bit instance with the ripple adder is swept over every combination of operation, operands, index and carry, so every carry and zero combination is reached in the narrow form.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

   typedef enum logic [3:0] {
      OP_ADDC  = 4'd0,
      OP_SUBC  = 4'd1,
      OP_ADD   = 4'd2,
      OP_SUB   = 4'd3,
      OP_ROTR  = 4'd4,
      OP_ROTL  = 4'd5,
      OP_SHFR  = 4'd6,
      OP_SHFL  = 4'd7,
      OP_INV   = 4'd8,
      OP_XOR   = 4'd9,
      OP_OR    = 4'd10,
      OP_AND   = 4'd11,
      OP_BKEEP = 4'd12,
      OP_BFLIP = 4'd13,
      OP_BSET  = 4'd14,
      OP_BCLR  = 4'd15
   } alu_op_e;

   // operation class: bit 3 selects logic, bit 2 selects shifter within arithmetic
   function automatic logic op_is_logic(input alu_op_e op);
      return op[3];
   endfunction

   function automatic logic op_is_shift(input alu_op_e op);
      return !op[3] && op[2];
   endfunction

endpackage

// File: rtl/alu16_addsub.sv
module alu16_addsub
   import alu16_pkg::*;
#(
   parameter int WIDTH  = 16,
   parameter bit RIPPLE = 1'b0
) (
   input  alu_op_e           op_i,
   input  logic [WIDTH-1:0]  a_i,
   input  logic [WIDTH-1:0]  b_i,
   input  logic              carry_i,
   output logic [WIDTH-1:0]  sum_o,
   output logic              carry_o
);

   logic             sub_sel;
   logic             chain_sel;
   logic             cin_eff;
   logic [WIDTH-1:0] b_eff;

   always_comb begin
      sub_sel   = (op_i == OP_SUBC) || (op_i == OP_SUB);
      chain_sel = (op_i == OP_SUBC) || (op_i == OP_ADDC);
      b_eff     = sub_sel ? ~b_i : b_i;
      cin_eff   = chain_sel ? carry_i : sub_sel;
   end

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = cin_eff;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_o[i]     = a_i[i] ^ b_eff[i] ^ chain[i];
            assign chain[i+1]   = (a_i[i] & b_eff[i]) | (chain[i] & (a_i[i] ^ b_eff[i]));
         end
         assign carry_o = chain[WIDTH];
      end else begin : g_flat
         assign {carry_o, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_eff};
      end
   endgenerate

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
   import alu16_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  alu_op_e           op_i,
   input  logic [WIDTH-1:0]  a_i,
   output logic [WIDTH-1:0]  res_o,
   output logic              carry_o
);

   always_comb begin
      unique case (op_i)
         OP_ROTR: begin
            res_o   = {a_i[0], a_i[WIDTH-1:1]};
            carry_o = a_i[0];
         end
         OP_ROTL: begin
            res_o   = {a_i[WIDTH-2:0], a_i[WIDTH-1]};
            carry_o = a_i[WIDTH-1];
         end
         OP_SHFR: begin
            res_o   = {1'b0, a_i[WIDTH-1:1]};
            carry_o = a_i[0];
         end
         default: begin
            res_o   = {a_i[WIDTH-2:0], 1'b0};
            carry_o = a_i[WIDTH-1];
         end
      endcase
   end

endmodule

// File: rtl/alu16_bitwise.sv
module alu16_bitwise
   import alu16_pkg::*;
#(
   parameter int WIDTH = 16,
   parameter int IDX_W = $clog2(WIDTH)
) (
   input  alu_op_e           op_i,
   input  logic [WIDTH-1:0]  a_i,
   input  logic [WIDTH-1:0]  b_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic [WIDTH-1:0]  res_o
);

   logic [WIDTH-1:0] sel_mask;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_dec
         assign sel_mask[i] = (idx_i == IDX_W'(i));
      end
   endgenerate

   always_comb begin
      unique case (op_i)
         OP_INV:   res_o = ~a_i;
         OP_XOR:   res_o = a_i ^ b_i;
         OP_OR:    res_o = a_i | b_i;
         OP_AND:   res_o = a_i & b_i;
         OP_BKEEP: res_o = a_i & sel_mask;
         OP_BFLIP: res_o = a_i ^ sel_mask;
         OP_BSET:  res_o = a_i | sel_mask;
         default:  res_o = a_i & ~sel_mask;
      endcase
   end

endmodule

// File: rtl/alu16_bitops.sv
module alu16_bitops
   import alu16_pkg::*;
#(
   parameter int   WIDTH        = 16,
   parameter bit   ADDER_RIPPLE = 1'b0,
   localparam int  IDX_W        = $clog2(WIDTH)
) (
   input  logic [3:0]        op_i,
   input  logic [WIDTH-1:0]  src_a_i,
   input  logic [WIDTH-1:0]  src_b_i,
   input  logic [IDX_W-1:0]  bit_sel_i,
   input  logic              carry_i,
   output logic [WIDTH-1:0]  result_o,
   output logic              carry_o,
   output logic              zero_o
);

   generate
      if (WIDTH < 4) begin : g_chk_width
         $error("alu16_bitops: WIDTH must be at least 4");
      end
      if ((1 << IDX_W) != WIDTH) begin : g_chk_pow2
         $error("alu16_bitops: WIDTH must be a power of two");
      end
   endgenerate

   alu_op_e          op;
   logic [WIDTH-1:0] arith_res;
   logic             arith_c;
   logic [WIDTH-1:0] shift_res;
   logic             shift_c;
   logic [WIDTH-1:0] logic_res;

   assign op = alu_op_e'(op_i);

   alu16_addsub #(.WIDTH(WIDTH), .RIPPLE(ADDER_RIPPLE)) u_addsub (
      .op_i    (op),
      .a_i     (src_a_i),
      .b_i     (src_b_i),
      .carry_i (carry_i),
      .sum_o   (arith_res),
      .carry_o (arith_c)
   );

   alu16_shift #(.WIDTH(WIDTH)) u_shift (
      .op_i    (op),
      .a_i     (src_a_i),
      .res_o   (shift_res),
      .carry_o (shift_c)
   );

   alu16_bitwise #(.WIDTH(WIDTH), .IDX_W(IDX_W)) u_bitwise (
      .op_i    (op),
      .a_i     (src_a_i),
      .b_i     (src_b_i),
      .idx_i   (bit_sel_i),
      .res_o   (logic_res)
   );

   always_comb begin
      if (op_is_logic(op)) begin
         result_o = logic_res;
         carry_o  = carry_i;
      end else if (op_is_shift(op)) begin
         result_o = shift_res;
         carry_o  = shift_c;
      end else begin
         result_o = arith_res;
         carry_o  = arith_c;
      end
      zero_o = ~|result_o;
   end

endmodule

// File: rtl/alu16_bitops_chk.sv
module alu16_bitops_chk #(
   parameter int  WIDTH = 16,
   localparam int IDX_W = $clog2(WIDTH)
) (
   input logic [3:0]        op_i,
   input logic [WIDTH-1:0]  src_a_i,
   input logic [WIDTH-1:0]  src_b_i,
   input logic [IDX_W-1:0]  bit_sel_i,
   input logic              carry_i,
   input logic [WIDTH-1:0]  result_o,
   input logic              carry_o,
   input logic              zero_o
);

   logic [WIDTH:0] wide_a;
   logic [WIDTH:0] wide_b;
   logic [WIDTH:0] wide_r;

   always_comb begin
      wide_a = {1'b0, src_a_i};
      wide_b = {1'b0, src_b_i};
      wide_r = {carry_o, result_o};

      if (op_i == 4'd2)
         assert_add_sum_R1: assert (wide_r == wide_a + wide_b);

      if (op_i == 4'd0)
         assert_adc_sum_R2: assert (wide_r == wide_a + wide_b + {{WIDTH{1'b0}}, carry_i});

      if (op_i == 4'd3)
         assert_sub_noborrow_R3: assert (carry_o == (src_a_i >= src_b_i)
                                        && result_o + src_b_i == src_a_i);

      if (op_i == 4'd4 || op_i == 4'd5)
         assert_rot_keeps_ones_R4: assert ($countones(result_o) == $countones(src_a_i));

      if (op_i == 4'd6)
         assert_shr_fill_R5: assert (result_o[WIDTH-1] == 1'b0 && carry_o == src_a_i[0]);

      if (op_i == 4'd7)
         assert_shl_fill_R5: assert (result_o[0] == 1'b0 && carry_o == src_a_i[WIDTH-1]);

      if (op_i[3])
         assert_logic_carry_R6: assert (carry_o == carry_i);

      if (op_i == 4'd12)
         assert_keep_single_R7: assert ($countones(result_o) <= 1
                                         && result_o[bit_sel_i] == src_a_i[bit_sel_i]);

      if (op_i == 4'd14)
         assert_set_bit_R7: assert (result_o[bit_sel_i] == 1'b1);

      if (zero_o)
         assert_zero_means_empty_R8: assert (result_o == '0);
      else
         assert_nonzero_means_set_R8: assert (result_o != '0);
   end

endmodule

bind alu16_bitops alu16_bitops_chk #(.WIDTH(WIDTH)) u_chk (
   .op_i      (op_i),
   .src_a_i   (src_a_i),
   .src_b_i   (src_b_i),
   .bit_sel_i (bit_sel_i),
   .carry_i   (carry_i),
   .result_o  (result_o),
   .carry_o   (carry_o),
   .zero_o    (zero_o)
);

// File: tb/alu16_bitops_test.sv
`timescale 1ns/1ps
module alu16_bitops_test;

   logic clk = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   // wide instance (default configuration)
   logic [3:0]  op16;
   logic [15:0] a16, b16, r16;
   logic [3:0]  idx16;
   logic        c16, co16, z16;

   alu16_bitops uut (
      .op_i(op16), .src_a_i(a16), .src_b_i(b16), .bit_sel_i(idx16),
      .carry_i(c16), .result_o(r16), .carry_o(co16), .zero_o(z16)
   );

   // narrow instance with ripple adder, swept exhaustively
   logic [3:0] op4, a4, b4, r4;
   logic [1:0] idx4;
   logic       c4, co4, z4;

   alu16_bitops #(.WIDTH(4), .ADDER_RIPPLE(1'b1)) uut_narrow (
      .op_i(op4), .src_a_i(a4), .src_b_i(b4), .bit_sel_i(idx4),
      .carry_i(c4), .result_o(r4), .carry_o(co4), .zero_o(z4)
   );

   function automatic void model(input int w, input int op, input int a, input int b,
                                 input int idx, input int cin,
                                 output int res, output int co);
      int m;
      int s;
      m   = (1 << w) - 1;
      s   = 0;
      co  = cin;
      res = 0;
      case (op)
         0:  begin s = a + b + cin;          res = s & m; co = (s >> w) & 1; end
         1:  begin s = a + ((~b) & m) + cin; res = s & m; co = (s >> w) & 1; end
         2:  begin s = a + b;                res = s & m; co = (s >> w) & 1; end
         3:  begin s = a + ((~b) & m) + 1;   res = s & m; co = (s >> w) & 1; end
         4:  begin res = (a >> 1) | ((a & 1) << (w - 1)); co = a & 1; end
         5:  begin res = ((a << 1) & m) | ((a >> (w - 1)) & 1); co = (a >> (w - 1)) & 1; end
         6:  begin res = a >> 1; co = a & 1; end
         7:  begin res = (a << 1) & m; co = (a >> (w - 1)) & 1; end
         8:  res = (~a) & m;
         9:  res = a ^ b;
         10: res = a | b;
         11: res = a & b;
         12: res = a & (1 << idx);
         13: res = a ^ (1 << idx);
         14: res = a | (1 << idx);
         default: res = a & ~(1 << idx) & m;
      endcase
   endfunction

   function automatic string tag(input int op);
      case (op)
         0: return "R2";
         1, 3: return "R3";
         2: return "R1";
         4, 5: return "R4";
         6, 7: return "R5";
         8, 9, 10, 11: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic judge(input string where, input int op, input int got_r, input int got_c,
                        input int got_z, input int exp_r, input int exp_c);
      int exp_z;
      exp_z = (exp_r == 0) ? 1 : 0;
      checks++;
      if (got_r != exp_r || got_c != exp_c) begin
         errors++;
         $display("FAIL %s %s op=%0d result=%h carry=%0d expected result=%h carry=%0d",
                  tag(op), where, op, got_r, got_c, exp_r, exp_c);
      end
      checks++;
      if (got_z != exp_z) begin
         errors++;
         $display("FAIL R8 %s op=%0d zero=%0d expected %0d", where, op, got_z, exp_z);
      end
   endtask

   task automatic run16(input int op, input int a, input int b, input int idx, input int cin);
      int er, ec;
      op16 = op[3:0]; a16 = a[15:0]; b16 = b[15:0]; idx16 = idx[3:0]; c16 = cin[0];
      #1;
      model(16, op, a, b, idx, cin, er, ec);
      judge("w16", op, int'(r16), int'(co16), int'(z16), er, ec);
   endtask

   task automatic run4(input int op, input int a, input int b, input int idx, input int cin);
      int er, ec;
      op4 = op[3:0]; a4 = a[3:0]; b4 = b[3:0]; idx4 = idx[1:0]; c4 = cin[0];
      #1;
      model(4, op, a, b, idx, cin, er, ec);
      judge("w4", op, int'(r4), int'(co4), int'(z4), er, ec);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int corner [8];
      logic [31:0] lfsr;
      corner = '{32'h0000, 32'h0001, 32'h7FFF, 32'h8000, 32'hFFFF, 32'h5555, 32'hAAAA, 32'h00FF};
      lfsr = 32'h1ACE_B00C;

      op16 = '0; a16 = '0; b16 = '0; idx16 = '0; c16 = 1'b0;
      op4  = '0; a4  = '0; b4  = '0; idx4  = '0; c4  = 1'b0;
      @(negedge clk);

      // idle inputs: add-with-carry of zeros gives zero result and zero flag (R2, R8)
      run16(0, 0, 0, 0, 0);

      // carry and zero together (R1, R8): 0x8000 + 0x8000
      run16(2, 16'h8000, 16'h8000, 0, 0);
      // equal subtract: zero result, no borrow (R3)
      run16(3, 16'h1234, 16'h1234, 0, 0);
      // subtract-with-carry, carry clear: 0 - 0 - 1 borrows (R3)
      run16(1, 0, 0, 0, 0);
      // shift out the last set bit: zero and carry (R5)
      run16(6, 1, 0, 0, 0);
      run16(7, 16'h8000, 0, 0, 0);
      // rotate of single bit wraps (R4)
      run16(4, 1, 0, 0, 0);
      // keep bit at top index (R7)
      run16(12, 16'hFFFF, 0, 15, 1);
      run16(15, 16'h8000, 0, 15, 0);

      // corner grid on the wide instance
      for (int op = 0; op < 16; op++)
         for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
               for (int cin = 0; cin < 2; cin++)
                  run16(op, corner[i], corner[j], (i * 5 + j) % 16, cin);

      // pseudo-random operands on the wide instance
      for (int n = 0; n < 4000; n++) begin
         lfsr = lfsr ^ (lfsr << 13);
         lfsr = lfsr ^ (lfsr >> 17);
         lfsr = lfsr ^ (lfsr << 5);
         run16(n % 16, int'(lfsr[15:0]), int'(lfsr[31:16]), int'(lfsr[7:4]), int'(lfsr[9]));
      end

      // R9: single-operand codes ignore src_b_i
      for (int op = 4; op < 16; op++) begin
         logic [15:0] r_lo, r_hi;
         logic        c_lo, c_hi;
         if (op >= 9 && op <= 11) continue;
         op16 = op[3:0]; a16 = 16'hC3A5; idx16 = 4'd6; c16 = 1'b1;
         b16 = 16'h0000; #1; r_lo = r16; c_lo = co16;
         b16 = 16'hFFFF; #1; r_hi = r16; c_hi = co16;
         checks++;
         if (r_lo != r_hi || c_lo != c_hi) begin
            errors++;
            $display("FAIL R9 op=%0d result=%h carry=%0d expected result=%h carry=%0d",
                     op, r_hi, c_hi, r_lo, c_lo);
         end
      end

      // exhaustive sweep of the narrow ripple-adder instance
      for (int op = 0; op < 16; op++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
               for (int idx = 0; idx < 4; idx++)
                  for (int cin = 0; cin < 2; cin++)
                     run4(op, a, b, idx, cin);

      finish_run();
   end

endmodule